// File: doc/BRIEF.md
# Serial link power-up sequencer

This block brings a low-swing serial display link from its off state to streaming video. It runs on the pixel clock and steps through a fixed start-up handshake. It first waits out a bias-up period with no line current. It then drives the clock line low, high and low again for fixed cycle counts, so that the receiver can wake up and calibrate its current sources. It then holds off for PLL lock before it lets data stream. The outputs are line-state codes for the clock line and for the data lines, plus a stream-enable. The current drivers and the PLL that act on these codes sit outside the block.

Two conditions stop the link. The active-low power-down pin forces the link off at once. A clock-stop detector runs on a free-running reference clock and watches a toggle flag from the pixel-clock domain. When the pixel clock has been static for too long, the detector also forces the link off. Either condition clears the pixel-clock state asynchronously. The release is synchronised through two pixel-clock flops, so every new start begins again from bias-up.

Top module: `link_pwrup_seq`

## Requirements
- R1: While reset is asserted, both line codes are 2'b00 (zero current) and stream_en_o is 0. The codes are 00 for off, 01 for logic low (high current), 10 for logic high (low current) and 11 for active.
- R2: After pd_ni rises with the pixel clock running, both lines stay at 00 for exactly 202 pixel-clock rising edges: 2 edges of synchroniser delay and then 200 edges of bias-up.
- R3: The clock line then reads 01 for 200 pixel clocks while the data lines stay at 00.
- R4: The clock line then reads 10 for 20 pixel clocks while the data lines stay at 00.
- R5: The clock line then reads 01 for 8 pixel clocks with the data lines at 00. After that, the clock line stays at 01 and the data lines read 01 for the 600-cycle lock hold-off.
- R6: After the hold-off, both lines read 11 and stream_en_o is 1. This holds for as long as the link stays enabled.
- R7: Driving pd_ni low forces both lines to 00 and stream_en_o to 0 without waiting for a pixel-clock edge.
- R8: When the pixel clock is static for STOP_REF_CYC reference cycles (four pixel periods by default), the link goes to 00 and 0. When the pixel clock restarts with pd_ni high, the full start-up sequence runs again with the phase lengths of R3 to R5.
- R9: A power-down in the middle of the start-up sequence aborts it. The next rise of pd_ni restarts from bias-up with the timing of R2.
- R10: While pd_ni is low, a running pixel clock does not start the sequence, and both lines remain at 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Pixel clock, clocks the sequencer |
| ref_clk_i | input | 1 | Free-running reference clock for clock-stop detection |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pd_ni | input | 1 | Active-low power-down; high enables the link |
| mc_state_o | output | 2 | Clock-line state code (00 off, 01 low, 10 high, 11 active) |
| md_state_o | output | 2 | Data-line state code (same encoding) |
| stream_en_o | output | 1 | High while video data may be streamed |

## Verification
The hardest case to reach is a stop of the pixel clock partway through start-up. Once the clock stops, the sequencer gets no more edges and cannot react by itself. Only the reference-domain detector can clear it, and that clear must still be in place when the clock restarts. The bench freezes its pixel-clock generator once after the link is streaming and once inside the lock hold-off. It then restarts the generator and checks the length of every phase of the rerun through the scoreboard, so that a half-cleared state or a glitch of the old phase shows up as an unexpected run.

// File: rtl/link_seq_pkg.sv
`timescale 1ns/1ps
package link_seq_pkg;

  typedef enum logic [1:0] {
    LC_OFF  = 2'b00,
    LC_LOW  = 2'b01,
    LC_HIGH = 2'b10,
    LC_ACT  = 2'b11
  } line_code_e;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_BIAS,
    PH_CLK_LO1,
    PH_CLK_HI,
    PH_CLK_LO2,
    PH_HOLD,
    PH_STREAM
  } phase_e;

endpackage

// File: rtl/lps_sync.sv
`timescale 1ns/1ps
module lps_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/lps_clk_stop_det.sv
`timescale 1ns/1ps
module lps_clk_stop_det #(
  parameter int STOP_REF_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic stop_o
);

  localparam int            CW     = $clog2(STOP_REF_CYC + 1);
  localparam logic [CW-1:0] LIM    = CW'(STOP_REF_CYC);
  localparam logic [CW-1:0] LIM_M1 = CW'(STOP_REF_CYC - 1);

  logic          tgl_s, tgl_d, chg;
  logic [CW-1:0] idle_q;
  logic          stop_q;

  lps_sync #(.STAGES(2), .RST_VAL(1'b0)) u_tgl_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (tgl_i),
    .q_o   (tgl_s)
  );

  assign chg = tgl_s ^ tgl_d;

  // stop starts asserted so that a link only comes up once the pixel clock is seen running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_d  <= 1'b0;
      idle_q <= LIM;
      stop_q <= 1'b1;
    end else begin
      tgl_d <= tgl_s;
      if (chg) begin
        idle_q <= '0;
        stop_q <= 1'b0;
      end else if (idle_q != LIM) begin
        idle_q <= idle_q + 1'b1;
        stop_q <= (idle_q == LIM_M1);
      end
    end
  end

  assign stop_o = stop_q;

  a_r8_stop_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_q) |-> ($past(idle_q) == LIM_M1 && !$past(chg)));

  a_r8_toggle_clears_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg |=> !stop_q);

endmodule

// File: rtl/lps_phase_seq.sv
`timescale 1ns/1ps
module lps_phase_seq
  import link_seq_pkg::*;
#(
  parameter int BIAS_CYC = 200,
  parameter int LO1_CYC  = 200,
  parameter int HI_CYC   = 20,
  parameter int LO2_CYC  = 8,
  parameter int HOLD_CYC = 600
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [1:0] mc_o,
  output logic [1:0] md_o,
  output logic       stream_o
);

  localparam int MAX_AB  = (BIAS_CYC > LO1_CYC) ? BIAS_CYC : LO1_CYC;
  localparam int MAX_CD  = (HI_CYC > LO2_CYC) ? HI_CYC : LO2_CYC;
  localparam int MAX_ABC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int MAX_ALL = (MAX_ABC > HOLD_CYC) ? MAX_ABC : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  line_code_e       mc_c, md_c;

  function automatic logic [CNT_W-1:0] last_of(input phase_e p);
    case (p)
      PH_BIAS:    return CNT_W'(BIAS_CYC - 1);
      PH_CLK_LO1: return CNT_W'(LO1_CYC - 1);
      PH_CLK_HI:  return CNT_W'(HI_CYC - 1);
      PH_CLK_LO2: return CNT_W'(LO2_CYC - 1);
      PH_HOLD:    return CNT_W'(HOLD_CYC - 1);
      default:    return '0;
    endcase
  endfunction

  function automatic phase_e succ(input phase_e p);
    case (p)
      PH_BIAS:    return PH_CLK_LO1;
      PH_CLK_LO1: return PH_CLK_HI;
      PH_CLK_HI:  return PH_CLK_LO2;
      PH_CLK_LO2: return PH_HOLD;
      default:    return PH_STREAM;
    endcase
  endfunction

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_OFF: begin
        phase_d = PH_BIAS;
        cnt_d   = '0;
      end
      PH_STREAM: ;
      default: begin
        if (cnt_q == last_of(phase_q)) begin
          phase_d = succ(phase_q);
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  // rst_ni here is the synchronised enable: power-down and clock stop clear it asynchronously
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  always_comb begin
    mc_c = LC_OFF;
    md_c = LC_OFF;
    case (phase_q)
      PH_CLK_LO1, PH_CLK_LO2: mc_c = LC_LOW;
      PH_CLK_HI:              mc_c = LC_HIGH;
      PH_HOLD: begin
        mc_c = LC_LOW;
        md_c = LC_LOW;
      end
      PH_STREAM: begin
        mc_c = LC_ACT;
        md_c = LC_ACT;
      end
      default: ;
    endcase
  end

  assign mc_o     = mc_c;
  assign md_o     = md_c;
  assign stream_o = (phase_q == PH_STREAM);

  a_r3_lo1_follows_bias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CLK_LO1 && $past(phase_q) != PH_CLK_LO1)
      |-> ($past(phase_q) == PH_BIAS && $past(cnt_q) == CNT_W'(BIAS_CYC - 1)));

  a_r4_hi_follows_lo1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CLK_HI && $past(phase_q) != PH_CLK_HI)
      |-> ($past(phase_q) == PH_CLK_LO1 && $past(cnt_q) == CNT_W'(LO1_CYC - 1)));

  a_r6_stream_after_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STREAM && $past(phase_q) != PH_STREAM)
      |-> ($past(phase_q) == PH_HOLD && $past(cnt_q) == CNT_W'(HOLD_CYC - 1)));

  a_r5_hold_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD) |-> (cnt_q < CNT_W'(HOLD_CYC)));

endmodule

// File: rtl/link_pwrup_seq.sv
`timescale 1ns/1ps
module link_pwrup_seq
  import link_seq_pkg::*;
#(
  parameter int BIAS_CYC     = 200,
  parameter int LO1_CYC      = 200,
  parameter int HI_CYC       = 20,
  parameter int LO2_CYC      = 8,
  parameter int HOLD_CYC     = 600,
  parameter int STOP_REF_CYC = 20
) (
  input  logic       pclk_i,
  input  logic       ref_clk_i,
  input  logic       rst_ni,
  input  logic       pd_ni,
  output logic [1:0] mc_state_o,
  output logic [1:0] md_state_o,
  output logic       stream_en_o
);

  logic tgl_q;
  logic stop_ref;
  logic clr_n;
  logic run_n;

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  lps_clk_stop_det #(.STOP_REF_CYC(STOP_REF_CYC)) u_stop_det (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .tgl_i (tgl_q),
    .stop_o(stop_ref)
  );

  // asynchronous clear, release re-timed into the pixel-clock domain
  assign clr_n = rst_ni & pd_ni & ~stop_ref;

  lps_sync #(.STAGES(2), .RST_VAL(1'b0)) u_run_sync (
    .clk_i (pclk_i),
    .rst_ni(clr_n),
    .d_i   (1'b1),
    .q_o   (run_n)
  );

  lps_phase_seq #(
    .BIAS_CYC(BIAS_CYC),
    .LO1_CYC (LO1_CYC),
    .HI_CYC  (HI_CYC),
    .LO2_CYC (LO2_CYC),
    .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk_i   (pclk_i),
    .rst_ni  (run_n),
    .mc_o    (mc_state_o),
    .md_o    (md_state_o),
    .stream_o(stream_en_o)
  );

  a_r7_pd_low_means_off: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    !pd_ni |=> (mc_state_o == LC_OFF && md_state_o == LC_OFF && !stream_en_o));

  a_r6_stream_lines_active: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    stream_en_o |-> (pd_ni && !stop_ref));

endmodule

// File: tb/link_pwrup_seq_bench.sv
`timescale 1ns/1ps
module link_pwrup_seq_bench;

  logic ref_clk = 1'b0;
  logic pclk    = 1'b0;
  logic pclk_run = 1'b1;
  logic rst_n   = 1'b0;
  logic pd_n    = 1'b0;
  logic [1:0] mc, md;
  logic en;

  link_pwrup_seq u_link_pwrup_seq (
    .pclk_i     (pclk),
    .ref_clk_i  (ref_clk),
    .rst_ni     (rst_n),
    .pd_ni      (pd_n),
    .mc_state_o (mc),
    .md_state_o (md),
    .stream_en_o(en)
  );

  always #4 ref_clk = ~ref_clk;
  initial forever begin
    #20;
    if (pclk_run) pclk = ~pclk;
  end

  typedef struct packed {
    logic [1:0]  mc;
    logic [1:0]  md;
    logic        en;
    logic [15:0] len;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;
  int   mark_req  = 0;
  int   mark_seen = 0;
  logic mon_on = 1'b0;
  logic [4:0] cur;
  logic [4:0] smp;
  int   run_len = 0;
  bit   cur_valid = 1'b0;
  exp_t e;

  function automatic string tag_of(input logic [4:0] t);
    if (t[0])              return "R6";
    if (t[2:1] == 2'b01)   return "R5";
    if (t[4:3] == 2'b10)   return "R4";
    if (t[4:3] == 2'b01)   return "R3";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic push_seq(input int off_len, input int cut);
    int   mcv[6]  = '{0, 1, 2, 1, 1, 3};
    int   mdv[6]  = '{0, 0, 0, 0, 1, 3};
    int   lens[6] = '{0, 200, 20, 8, 600, 0};
    exp_t x;
    lens[0] = off_len;
    for (int i = 0; i <= cut; i++) begin
      x.mc  = mcv[i][1:0];
      x.md  = mdv[i][1:0];
      x.en  = (i == 5);
      x.len = (i == cut) ? 16'd0 : lens[i][15:0];
      q.push_back(x);
    end
  endtask

  task automatic wait_pclk(input int n);
    repeat (n) @(negedge pclk);
  endtask

  // monitor: measures each run of a constant output tuple and scores it
  always @(negedge pclk) begin
    if (mon_on) begin
      smp = {mc, md, en};
      if (!cur_valid) begin
        cur = smp; run_len = 1; cur_valid = 1'b1;
      end else if (smp != cur) begin
        if (q.size() == 0) begin
          chk(1'b0, tag_of(cur), "unexpected line change", int'(smp), int'(cur));
        end else begin
          e = q.pop_front();
          chk({e.mc, e.md, e.en} == cur, tag_of(cur), "line state",
              int'(cur), int'({e.mc, e.md, e.en}));
          if (e.len != 0)
            chk(run_len == int'(e.len), tag_of(cur), "phase length", run_len, int'(e.len));
        end
        cur = smp; run_len = 1;
      end else begin
        run_len++;
      end
      if (mark_req != mark_seen) begin
        run_len   = 1;
        mark_seen = mark_req;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge ref_clk);
    chk(1'b0, "R6", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #30;
    chk(mc == 2'b00, "R1", "mc in reset", int'(mc), 0);
    chk(md == 2'b00, "R1", "md in reset", int'(md), 0);
    chk(en == 1'b0,  "R1", "en in reset", int'(en), 0);
    #30 rst_n = 1'b1;
    @(negedge pclk);
    mon_on = 1'b1;

    // R10: running clock, power-down held low
    wait_pclk(300);
    #1;
    chk(mc == 2'b00 && md == 2'b00, "R10", "lines while pd low", int'({mc, md}), 0);

    // R2..R6: plain start
    push_seq(202, 5);
    mark_req++;
    pd_n = 1'b1;
    wait_pclk(1050);
    #1 chk(en == 1'b1 && mc == 2'b11, "R6", "streaming", int'({mc, en}), 7);

    // R7: power-down while streaming, checked between clock edges
    #1 pd_n = 1'b0;
    #1 chk(mc == 2'b00 && md == 2'b00 && en == 1'b0, "R7", "immediate off",
           int'({mc, md, en}), 0);
    wait_pclk(20);

    // R9: abort during the clock-high phase, then restart
    #1;
    push_seq(202, 2);
    mark_req++;
    pd_n = 1'b1;
    wait_pclk(202 + 200 + 5);
    #1 pd_n = 1'b0;
    #1 chk(mc == 2'b00 && en == 1'b0, "R9", "abort off", int'({mc, en}), 0);
    wait_pclk(10);
    #1;
    push_seq(202, 5);
    mark_req++;
    pd_n = 1'b1;
    wait_pclk(1050);
    #1 chk(en == 1'b1, "R9", "stream after restart", int'(en), 1);

    // R8: pixel clock stops while streaming
    #1 pclk_run = 1'b0;
    repeat (40) @(posedge ref_clk);
    #1 chk(mc == 2'b00 && md == 2'b00 && en == 1'b0, "R8", "off on clock stop",
           int'({mc, md, en}), 0);
    push_seq(0, 4);
    pclk_run = 1'b1;
    wait_pclk(600);

    // R8: stop again inside the hold-off
    #1 chk(mc == 2'b01 && md == 2'b01, "R8", "in hold-off", int'({mc, md}), 5);
    pclk_run = 1'b0;
    repeat (40) @(posedge ref_clk);
    #1 chk(mc == 2'b00 && en == 1'b0, "R8", "off on stop in hold", int'({mc, en}), 0);
    push_seq(0, 5);
    pclk_run = 1'b1;
    wait_pclk(1100);
    #1 chk(en == 1'b1 && md == 2'b11, "R8", "stream after clock restart", int'({md, en}), 7);

    wait_pclk(5);
    chk(q.size() == 1, "R6", "scoreboard drained", q.size(), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule